// File: doc/BRIEF.md
# Unscaled Halfword Load/Store Unit

This unit executes one family of 32-bit instruction words. Each word moves a single 16-bit halfword between memory and a 64-bit register file. The unit first checks the fixed opcode bits of the word. It then pulls out a two-bit operation selector, a signed 9-bit byte offset and two 5-bit register numbers. The effective address is formed from the base register, or from the stack pointer when the base number is 31, plus the offset with no scaling. The unit issues one halfword access on a request/response memory port. A load writes the fetched halfword back to the register file, zero-extended or sign-extended to a 32-bit or 64-bit destination.

Instructions arrive on a valid/ready stream. `in_ready` is high only while the unit is idle, so a word is accepted on a cycle where both `in_valid` and `in_ready` are high. After that, `in_ready` stays low until the access has finished and any register write has been made. On the memory request side, `mem_req_valid` and all request fields stay stable until `mem_req_ready` is sampled high. The response channel has no back-pressure: the memory may raise `mem_rsp_valid` for one cycle at any time after the request handshake. The register file read ports are combinational.

The number of cycles from acceptance to the return of `in_ready` depends only on the instruction fields and on the memory handshake timing. It never depends on the data value that is loaded or stored.

Top module: `hwls_unit`

## Requirements
- R1: A word is legal only when bits 31:30 = 01, bits 29:24 = 111000, bit 21 = 0 and bits 11:10 = 00. An illegal word pulses `undef_o` for one cycle. It makes no memory request and no register write.
- R2: The selector is bits 23:22, the offset is bits 20:12, the base number is bits 9:5 and the transfer number is bits 4:0. The access address is the base plus the offset sign-extended to 64 bits, so the offset range is -256 to +255.
- R3: Base number 31 selects `sp_value` instead of a general register. If the low 4 bits of `sp_value` are not all zero, `align_fault_o` pulses for one cycle and no memory request or register write follows.
- R4: Selector 00 is a store. It makes one request with `mem_req_write` = 1 and `mem_req_wdata` = bits 15:0 of the transfer register, and it writes no register.
- R5: Selector 01 loads the halfword and writes it zero-extended to 64 bits.
- R6: Selector 11 sign-extends the halfword to 32 bits and writes it with bits 63:32 cleared.
- R7: Selector 10 sign-extends the halfword to the full 64 bits.
- R8: A load with transfer number 31 performs its memory access but writes no register.
- R9: `mem_req_tagchk` is 1 exactly when the base number is not 31. `mem_req_priv` is 1 exactly when `cur_el` sampled at acceptance is nonzero.
- R10: `in_ready` is low from the cycle after acceptance until the write-back cycle has ended. A request that has not been accepted holds `mem_req_valid` and `mem_req_addr` steady. The register write comes in the cycle after the response.
- R11: For the same instruction and the same memory timing, the number of cycles from acceptance to `in_ready` is the same whatever the data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_insn | input | 32 | Instruction word |
| cur_el | input | 2 | Current exception level, nonzero means privileged |
| sp_value | input | 64 | Stack pointer value |
| rf_raddr_base | output | 5 | Base register read number |
| rf_rdata_base | input | 64 | Base register read data |
| rf_raddr_data | output | 5 | Store source register read number |
| rf_rdata_data | input | 16 | Low halfword of store source register |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write number |
| rf_wdata | output | 64 | Register write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 64 | Byte address of the halfword |
| mem_req_write | output | 1 | 1 for store, 0 for load |
| mem_req_wdata | output | 16 | Store data |
| mem_req_tagchk | output | 1 | Access is tag-checked |
| mem_req_priv | output | 1 | Access is privileged |
| mem_rsp_valid | input | 1 | Memory response valid, one cycle |
| mem_rsp_rdata | input | 16 | Loaded halfword |
| undef_o | output | 1 | Undefined-instruction pulse |
| align_fault_o | output | 1 | Stack-pointer alignment fault pulse |

## Verification
Two events can fall in the same cycle: the register write-back of one load, and the offer of the next instruction, which reads that same register as its base. The bench keeps `in_valid` high with a second word whose base number equals the first load's transfer number. It then checks that the second request address is built from the freshly written value. This shows that the second word was not accepted before the write-back cycle ended. A further pair of runs with identical memory timing compares the busy cycle counts for all-zero and all-one loaded data.

// File: rtl/hwls_pkg.sv
package hwls_pkg;
  localparam int INSN_W = 32;
  localparam int IMM_W  = 9;
  localparam int RA_W   = 5;
  localparam int HW_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_REQ,
    ST_WAIT,
    ST_WB
  } hwls_state_t;

  typedef struct packed {
    logic             legal;
    logic             is_load;
    logic             sgn;
    logic             wide;
    logic [IMM_W-1:0] imm;
    logic [RA_W-1:0]  rn;
    logic [RA_W-1:0]  rt;
  } hwls_dec_t;
endpackage

// File: rtl/hwls_decode.sv
module hwls_decode
  import hwls_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output hwls_dec_t         dec
);
  logic [1:0] sel;
  logic       fixed_ok;

  always_comb begin
    fixed_ok = (insn[31:30] == 2'b01) && (insn[29:24] == 6'b111000) &&
               (insn[21] == 1'b0) && (insn[11:10] == 2'b00);
    sel         = insn[23:22];
    dec.legal   = fixed_ok;
    dec.imm     = insn[20:12];
    dec.rn      = insn[9:5];
    dec.rt      = insn[4:0];
    dec.sgn     = sel[1];
    dec.is_load = sel[1] | sel[0];
    dec.wide    = sel[1] & ~sel[0];
  end
endmodule

// File: rtl/hwls_agen.sv
module hwls_agen #(
  parameter int XLEN       = 64,
  parameter int IMM_W      = 9,
  parameter int RA_W       = 5,
  parameter int ALIGN_BITS = 4
) (
  input  logic [RA_W-1:0]  rn,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  gpr_base,
  input  logic [XLEN-1:0]  sp_base,
  output logic [XLEN-1:0]  addr,
  output logic             misalign,
  output logic             tagchk
);
  localparam int EXT_W = XLEN - IMM_W;
  localparam logic [RA_W-1:0] SP_NUM = '1;

  logic             use_sp;
  logic [XLEN-1:0]  base;
  logic [XLEN-1:0]  offs;

  always_comb begin
    use_sp   = (rn == SP_NUM);
    base     = use_sp ? sp_base : gpr_base;
    offs     = {{EXT_W{imm[IMM_W-1]}}, imm};
    addr     = base + offs;
    misalign = use_sp && (sp_base[ALIGN_BITS-1:0] != '0);
    tagchk   = ~use_sp;
  end
endmodule

// File: rtl/hwls_extend.sv
module hwls_extend #(
  parameter int XLEN   = 64,
  parameter int HW     = 16,
  parameter int NARROW = 32
) (
  input  logic [HW-1:0]   raw,
  input  logic            sgn,
  input  logic            wide,
  output logic [XLEN-1:0] ext
);
  localparam int PAD_N = NARROW - HW;
  localparam int PAD_W = XLEN - HW;
  localparam int TOP_N = XLEN - NARROW;

  logic [NARROW-1:0] narrow_val;

  always_comb begin
    narrow_val = sgn ? {{PAD_N{raw[HW-1]}}, raw} : {{PAD_N{1'b0}}, raw};
    if (wide)
      ext = {{PAD_W{raw[HW-1]}}, raw};
    else
      ext = {{TOP_N{1'b0}}, narrow_val};
  end
endmodule

// File: rtl/hwls_unit.sv
module hwls_unit
  import hwls_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int ALIGN_BITS = 4,
  parameter int NARROW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [1:0]        cur_el,
  input  logic [XLEN-1:0]   sp_value,
  output logic [RA_W-1:0]   rf_raddr_base,
  input  logic [XLEN-1:0]   rf_rdata_base,
  output logic [RA_W-1:0]   rf_raddr_data,
  input  logic [HW_W-1:0]   rf_rdata_data,
  output logic              rf_we,
  output logic [RA_W-1:0]   rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic              mem_req_write,
  output logic [HW_W-1:0]   mem_req_wdata,
  output logic              mem_req_tagchk,
  output logic              mem_req_priv,
  input  logic              mem_rsp_valid,
  input  logic [HW_W-1:0]   mem_rsp_rdata,
  output logic              undef_o,
  output logic              align_fault_o
);
  localparam logic [RA_W-1:0] ZR_NUM = '1;

  hwls_state_t       state;
  logic [INSN_W-1:0] insn_q;
  logic              priv_q;
  logic [XLEN-1:0]   addr_q;
  logic [HW_W-1:0]   wdata_q;
  logic              tag_q;
  logic [XLEN-1:0]   load_q;

  hwls_dec_t         dec;
  logic [XLEN-1:0]   agen_addr;
  logic              agen_misalign;
  logic              agen_tag;
  logic [XLEN-1:0]   ext_val;

  hwls_decode u_dec (
    .insn (insn_q),
    .dec  (dec)
  );

  hwls_agen #(
    .XLEN       (XLEN),
    .IMM_W      (IMM_W),
    .RA_W       (RA_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_agen (
    .rn       (dec.rn),
    .imm      (dec.imm),
    .gpr_base (rf_rdata_base),
    .sp_base  (sp_value),
    .addr     (agen_addr),
    .misalign (agen_misalign),
    .tagchk   (agen_tag)
  );

  hwls_extend #(
    .XLEN   (XLEN),
    .HW     (HW_W),
    .NARROW (NARROW)
  ) u_ext (
    .raw  (mem_rsp_rdata),
    .sgn  (dec.sgn),
    .wide (dec.wide),
    .ext  (ext_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      insn_q  <= '0;
      priv_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      tag_q   <= 1'b0;
      load_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            insn_q <= in_insn;
            priv_q <= (cur_el != 2'b00);
            state  <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (!dec.legal || agen_misalign) begin
            state <= ST_IDLE;
          end else begin
            addr_q  <= agen_addr;
            wdata_q <= rf_rdata_data;
            tag_q   <= agen_tag;
            state   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            load_q <= ext_val;
            state  <= ST_WB;
          end
        end
        ST_WB: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    in_ready       = (state == ST_IDLE);
    undef_o        = (state == ST_EXEC) && !dec.legal;
    align_fault_o  = (state == ST_EXEC) && dec.legal && agen_misalign;
    rf_raddr_base  = dec.rn;
    rf_raddr_data  = dec.rt;
    mem_req_valid  = (state == ST_REQ);
    mem_req_addr   = addr_q;
    mem_req_write  = !dec.is_load;
    mem_req_wdata  = wdata_q;
    mem_req_tagchk = tag_q;
    mem_req_priv   = priv_q;
    rf_we          = (state == ST_WB) && dec.is_load && (dec.rt != ZR_NUM);
    rf_waddr       = dec.rt;
    rf_wdata       = load_q;
  end
endmodule

// File: rtl/hwls_checker.sv
module hwls_checker #(
  parameter int XLEN = 64,
  parameter int RA_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            rf_we,
  input logic [RA_W-1:0] rf_waddr,
  input logic            undef_o,
  input logic            align_fault_o
);
  localparam logic [RA_W-1:0] ZR = '1;

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (!mem_req_valid && !rf_we && !align_fault_o)); // R1

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault_o |=> (!mem_req_valid && !rf_we)); // R3

  AST_NO_ZR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != ZR)); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || rf_we) |-> !in_ready); // R10

  AST_WE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(mem_rsp_valid)); // R10
endmodule

bind hwls_unit hwls_checker #(
  .XLEN (XLEN),
  .RA_W (hwls_pkg::RA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .rf_we         (rf_we),
  .rf_waddr      (rf_waddr),
  .undef_o       (undef_o),
  .align_fault_o (align_fault_o)
);

// File: tb/sim_hwls_unit.sv
module sim_hwls_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [1:0]  cur_el = 2'b00;
  logic [63:0] sp_value = '0;
  logic [4:0]  rf_raddr_base, rf_raddr_data, rf_waddr;
  logic [63:0] rf_rdata_base, rf_wdata;
  logic [15:0] rf_rdata_data;
  logic        rf_we;
  logic        mem_req_valid, mem_req_write, mem_req_tagchk, mem_req_priv;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_rdata = '0;
  logic        undef_o, align_fault_o;

  logic [63:0] regs [32];
  int          checks = 0;
  int          errors = 0;
  int          mem_lat = 0;
  logic [15:0] mem_word = '0;
  int          wcnt = 0;
  logic        hs_q = 1'b0;
  int          req_cnt = 0, wr_cnt = 0, undef_cnt = 0, fault_cnt = 0;
  logic [63:0] last_addr;
  logic [15:0] last_wdata;
  logic        last_write, last_tag, last_priv;

  always #5 clk = ~clk;

  hwls_unit u0 (.*);

  assign rf_rdata_base = regs[rf_raddr_base];
  assign rf_rdata_data = regs[rf_raddr_data][15:0];

  always @(posedge clk) begin
    hs_q <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      req_cnt    <= req_cnt + 1;
      last_addr  <= mem_req_addr;
      last_write <= mem_req_write;
      last_wdata <= mem_req_wdata;
      last_tag   <= mem_req_tagchk;
      last_priv  <= mem_req_priv;
    end
    if (rf_we) begin
      regs[rf_waddr] <= rf_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (undef_o) undef_cnt <= undef_cnt + 1;
    if (align_fault_o) fault_cnt <= fault_cnt + 1;
  end

  always @(negedge clk) begin
    mem_rsp_valid = hs_q;
    mem_rsp_rdata = hs_q ? mem_word : 16'h0;
    if (mem_req_valid) begin
      if (wcnt >= mem_lat) mem_req_ready = 1'b1;
      else begin
        mem_req_ready = 1'b0;
        wcnt++;
      end
    end else begin
      mem_req_ready = 1'b0;
      wcnt = 0;
    end
  end

  function automatic logic [31:0] enc(input logic [1:0] opc, input logic [8:0] imm,
                                      input logic [4:0] rn, input logic [4:0] rt);
    return {2'b01, 6'b111000, opc, 1'b0, imm, 2'b00, rn, rt};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, output int cyc);
    in_valid = 1'b1;
    in_insn  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 0;
    while (!in_ready) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    chk("R10 reset ready", {63'b0, in_ready}, 64'd1);
    chk("R10 reset req", {63'b0, mem_req_valid}, 64'd0);
    chk("R10 reset we", {63'b0, rf_we}, 64'd0);
  endtask

  task automatic t_undef();
    int c, r0, w0, u0c;
    r0 = req_cnt; w0 = wr_cnt; u0c = undef_cnt;
    run(enc(2'b01, 9'h0, 5'd3, 5'd5) | 32'h0020_0000, c);
    run(enc(2'b01, 9'h0, 5'd3, 5'd5) | 32'h0000_0400, c);
    run(enc(2'b01, 9'h0, 5'd3, 5'd5) ^ 32'h4000_0000, c);
    chk("R1 undef pulses", 64'(undef_cnt - u0c), 64'd3);
    chk("R1 no request", 64'(req_cnt - r0), 64'd0);
    chk("R1 no write", 64'(wr_cnt - w0), 64'd0);
  endtask

  task automatic t_load_zext();
    int c;
    regs[3] = 64'h1000; mem_word = 16'h8123; cur_el = 2'b00;
    run(enc(2'b01, 9'h1FE, 5'd3, 5'd5), c);
    chk("R2 address base-2", last_addr, 64'hFFE);
    chk("R5 zero extend", regs[5], 64'h8123);
    chk("R9 tag gpr", {63'b0, last_tag}, 64'd1);
    chk("R9 priv el0", {63'b0, last_priv}, 64'd0);
    chk("R4 load not write", {63'b0, last_write}, 64'd0);
  endtask

  task automatic t_load_s32();
    int c;
    regs[3] = 64'h1000; mem_word = 16'h8001;
    regs[6] = 64'hAAAA_AAAA_AAAA_AAAA;
    run(enc(2'b11, 9'h010, 5'd3, 5'd6), c);
    chk("R2 address base+16", last_addr, 64'h1010);
    chk("R6 sign extend 32", regs[6], 64'h0000_0000_FFFF_8001);
  endtask

  task automatic t_load_s64();
    int c;
    regs[3] = 64'h1000; mem_word = 16'h8001; cur_el = 2'b01;
    run(enc(2'b10, 9'h0, 5'd3, 5'd7), c);
    chk("R7 sign extend 64 neg", regs[7], 64'hFFFF_FFFF_FFFF_8001);
    chk("R9 priv el1", {63'b0, last_priv}, 64'd1);
    mem_word = 16'h7001; cur_el = 2'b00;
    run(enc(2'b10, 9'h0, 5'd3, 5'd7), c);
    chk("R7 sign extend 64 pos", regs[7], 64'h7001);
  endtask

  task automatic t_store();
    int c, w0;
    w0 = wr_cnt;
    regs[3] = 64'h1000; regs[8] = 64'h1234_5678_9ABC_DEF0;
    run(enc(2'b00, 9'h0FF, 5'd3, 5'd8), c);
    chk("R4 store flag", {63'b0, last_write}, 64'd1);
    chk("R4 store data", {48'b0, last_wdata}, 64'hDEF0);
    chk("R2 address base+255", last_addr, 64'h10FF);
    chk("R4 no reg write", 64'(wr_cnt - w0), 64'd0);
  endtask

  task automatic t_sp();
    int c, r0, f0;
    sp_value = 64'h2000; regs[31] = 64'h5555; mem_word = 16'h0042;
    run(enc(2'b01, 9'h100, 5'd31, 5'd9), c);
    chk("R3 sp base -256", last_addr, 64'h1F00);
    chk("R9 no tag on sp", {63'b0, last_tag}, 64'd0);
    r0 = req_cnt; f0 = fault_cnt;
    sp_value = 64'h2008;
    run(enc(2'b01, 9'h0, 5'd31, 5'd9), c);
    chk("R3 fault pulse", 64'(fault_cnt - f0), 64'd1);
    chk("R3 no request", 64'(req_cnt - r0), 64'd0);
  endtask

  task automatic t_zr();
    int c, r0, w0;
    r0 = req_cnt; w0 = wr_cnt;
    regs[31] = 64'h5555; mem_word = 16'h9999;
    run(enc(2'b10, 9'h0, 5'd3, 5'd31), c);
    chk("R8 access made", 64'(req_cnt - r0), 64'd1);
    chk("R8 no write", 64'(wr_cnt - w0), 64'd0);
    chk("R8 reg kept", regs[31], 64'h5555);
  endtask

  task automatic t_latency();
    int c0, c1;
    mem_lat = 2;
    mem_word = 16'h0000;
    run(enc(2'b10, 9'h0, 5'd3, 5'd10), c0);
    mem_word = 16'hFFFF;
    run(enc(2'b10, 9'h0, 5'd3, 5'd10), c1);
    chk("R11 equal latency", 64'(c1), 64'(c0));
    mem_lat = 0;
  endtask

  task automatic t_overlap();
    int c;
    regs[3] = 64'h1000; mem_word = 16'h4000; mem_lat = 1;
    in_valid = 1'b1;
    in_insn  = enc(2'b01, 9'h0, 5'd3, 5'd11);
    @(negedge clk);
    in_insn  = enc(2'b01, 9'h004, 5'd11, 5'd12);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    c = 0;
    while (!in_ready) begin
      @(negedge clk);
      c++;
    end
    chk("R10 second uses written base", last_addr, 64'h4004);
    chk("R5 chained load", regs[12], 64'h4000);
    mem_lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_undef();
    t_load_zext();
    t_load_s32();
    t_load_s64();
    t_store();
    t_sp();
    t_zr();
    t_latency();
    t_overlap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule